// File: doc/BRIEF.md
# Regulator Power-Good and Overvoltage Supervisor

This block decides when one regulator rail reports itself ready and when it must be shut down for overvoltage. It watches two enable inputs, a power-on reset, a soft-start completion flag from the ramp controller and an overcurrent flag. It also takes the present DAC target code, the measured output voltage code, the latest received voltage-ID code and an 8-bit multi-rail configuration value. From these it drives an open-drain-style ready line, where 1 means the line is pulled low. It also drives a latched overvoltage fault and a shutdown request for the power stage.

The overvoltage limit depends on the phase of the rail. Before soft-start has finished, and at any time the rail is disabled, the output is compared against a fixed ceiling. Once ready has been reached, the limit follows the DAC target plus a fixed margin. Voltages are handled as 5 mV-per-LSB codes: the fixed ceiling of 2.3 V is code 460, and the 179 mV margin is rounded to 36 codes.

An off-code (voltage-ID 00h) normally drops ready. A rail whose configuration value is 01h instead keeps ready high through an off-code once soft-start has finished. A dual-rail controller uses two independent instances of this block. The first rail's configuration value defaults to 00h and the second rail's to 01h; the defaults are held outside this block.

Top module: `pg_ovp_sup`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `rdy_pull_low` is 1 and both `ovp_fault` and `shutdown_req` are 0.
- R2: With both enables high and `por` low, ready stays low (`rdy_pull_low`=1) while `ss_done` is 0. It goes high on the first clock edge that samples `ss_done`=1 with no fault present.
- R3: Either enable input low, or `por` high, at a clock edge drops ready at that edge.
- R4: `ocp_fault` sampled high while the rail is enabled pulls ready low and sets `shutdown_req` at that edge. Both hold, even after `ocp_fault` clears, until an enable input falls and rises again.
- R5: With `vid_code`=00h and `cfg_reg` not equal to 01h, ready drops at the next edge without a shutdown request. A non-zero code together with `ss_done`=1 restores ready one edge later.
- R6: With `cfg_reg`=01h, a `vid_code` of 00h received after ready has been reached leaves ready high.
- R7: Until ready has first been reached after an enable, and at any time the rail is disabled, `ovp_fault` sets when `vout_code` is greater than 460. A value of exactly 460 does not set it. The limit is not affected by `dac_code`.
- R8: After ready has been reached, the limit becomes `dac_code`+36: `ovp_fault` sets when `vout_code` exceeds that sum and not when it equals it, even if `vout_code` is below 460.
- R9: `ovp_fault` is sticky. Once set, it forces ready low and raises `shutdown_req` one edge later. It stays set after the overvoltage is gone, and clears only on `por` or on a rising edge of the combined enable.
- R10: While `por` is high, `ovp_fault` stays 0 whatever `vout_code` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_a | input | 1 | First enable input, active high |
| en_b | input | 1 | Second enable input, active high |
| por | input | 1 | Power-on reset in progress, active high |
| ss_done | input | 1 | Soft-start ramp has reached its target |
| ocp_fault | input | 1 | Overcurrent detected |
| dac_code | input | 10 | Present DAC target, 5 mV per LSB |
| vout_code | input | 10 | Measured output voltage, 5 mV per LSB |
| vid_code | input | 8 | Latest received voltage-ID code, 00h = off |
| cfg_reg | input | 8 | Multi-rail configuration, 01h keeps ready through an off-code |
| rdy_pull_low | output | 1 | 1 = ready line pulled low, 0 = released (ready) |
| ovp_fault | output | 1 | Latched overvoltage fault |
| shutdown_req | output | 1 | Request to shut down the power stage |

## Verification
The bench probes both overvoltage limits at exactly the limit and one code above it. A design that used greater-or-equal, or that switched to the tracking limit before ready, would trip at the limit itself or miss a trip below 460. Faults that vanish after one cycle are also driven. A design with a non-sticky latch would bring ready back, or would let a stale latch push the rail into the fault state on re-enable. The off-code is tried with both configuration values to catch a ready line that ignores the configuration, and the fault-clear path is tried separately through `por` and through an enable cycle.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_RAMP   = 3'd1,
    ST_ON     = 3'd2,
    ST_VIDOFF = 3'd3,
    ST_FAULT  = 3'd4
  } rail_state_t;
endpackage

// File: rtl/pgs_ovp_mon.sv
module pgs_ovp_mon #(
  parameter int CODE_W    = 10,
  parameter int FIXED_LIM = 460,
  parameter int TRACK_OFS = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic              en_rise,
  input  logic              track,
  input  logic [CODE_W-1:0] dac_code,
  input  logic [CODE_W-1:0] vout_code,
  output logic              ovp_fault
);
  localparam int EXT_W = CODE_W + 1;
  localparam logic [EXT_W-1:0] FIX_V = EXT_W'(FIXED_LIM);
  localparam logic [EXT_W-1:0] OFS_V = EXT_W'(TRACK_OFS);

  logic [EXT_W-1:0] limit;
  logic             over;

  always_comb begin
    limit = track ? ({1'b0, dac_code} + OFS_V) : FIX_V;
    over  = ({1'b0, vout_code} > limit);
  end

  always_ff @(posedge clk) begin
    if (rst) ovp_fault <= 1'b0;
    else     ovp_fault <= ~por & ((ovp_fault & ~en_rise) | over);
  end
endmodule

// File: rtl/pgs_ready_fsm.sv
module pgs_ready_fsm
  import pgs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic enabled,
  input  logic ss_done,
  input  logic fault,
  input  logic vid_off,
  input  logic keep_on_off,
  output logic rdy,
  output logic shut,
  output logic track
);
  rail_state_t st, nx;

  always_comb begin
    nx = st;
    if (!enabled) begin
      nx = ST_OFF;
    end else begin
      unique case (st)
        ST_OFF:    nx = fault ? ST_FAULT : ST_RAMP;
        ST_RAMP:   if (fault) nx = ST_FAULT; else if (ss_done) nx = ST_ON;
        ST_ON:     if (fault) nx = ST_FAULT;
                   else if (vid_off && !keep_on_off) nx = ST_VIDOFF;
        ST_VIDOFF: if (fault) nx = ST_FAULT;
                   else if (!vid_off && ss_done) nx = ST_ON;
        ST_FAULT:  nx = ST_FAULT;
        default:   nx = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_OFF;
      rdy   <= 1'b0;
      shut  <= 1'b0;
      track <= 1'b0;
    end else begin
      st    <= nx;
      rdy   <= (nx == ST_ON);
      shut  <= (nx == ST_FAULT);
      track <= enabled & (track | (nx == ST_ON));
    end
  end
endmodule

// File: rtl/pg_ovp_sup.sv
module pg_ovp_sup #(
  parameter int CODE_W    = 10,
  parameter int VID_W     = 8,
  parameter int CFG_W     = 8,
  parameter int FIXED_LIM = 460,
  parameter int TRACK_OFS = 36,
  parameter int CFG_KEEP  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_a,
  input  logic              en_b,
  input  logic              por,
  input  logic              ss_done,
  input  logic              ocp_fault,
  input  logic [CODE_W-1:0] dac_code,
  input  logic [CODE_W-1:0] vout_code,
  input  logic [VID_W-1:0]  vid_code,
  input  logic [CFG_W-1:0]  cfg_reg,
  output logic              rdy_pull_low,
  output logic              ovp_fault,
  output logic              shutdown_req
);
  localparam logic [CFG_W-1:0] KEEP_V = CFG_W'(CFG_KEEP);

  logic enabled, en_q, en_rise;
  logic rdy, track, fault;

  assign enabled = en_a & en_b & ~por;
  assign en_rise = enabled & ~en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= enabled;
  end

  pgs_ovp_mon #(
    .CODE_W(CODE_W), .FIXED_LIM(FIXED_LIM), .TRACK_OFS(TRACK_OFS)
  ) u_ovp (
    .clk(clk), .rst(rst), .por(por), .en_rise(en_rise), .track(track),
    .dac_code(dac_code), .vout_code(vout_code), .ovp_fault(ovp_fault)
  );

  assign fault = ocp_fault | (ovp_fault & ~en_rise);

  pgs_ready_fsm u_fsm (
    .clk(clk), .rst(rst), .enabled(enabled), .ss_done(ss_done),
    .fault(fault), .vid_off(vid_code == '0),
    .keep_on_off(cfg_reg == KEEP_V),
    .rdy(rdy), .shut(shutdown_req), .track(track)
  );

  assign rdy_pull_low = ~rdy;
endmodule

// File: rtl/pg_ovp_sup_chk.sv
module pg_ovp_sup_chk (
  input logic clk,
  input logic rst,
  input logic en_a,
  input logic en_b,
  input logic por,
  input logic ss_done,
  input logic ocp_fault,
  input logic rdy_pull_low,
  input logic ovp_fault,
  input logic shutdown_req
);
  assert_enable_drops_ready_R3: assert property (@(posedge clk) disable iff (rst)
    (!en_a || !en_b || por) |=> rdy_pull_low);

  assert_ready_rise_after_ss_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(rdy_pull_low) |-> $past(ss_done));

  assert_ocp_drops_ready_R4: assert property (@(posedge clk) disable iff (rst)
    (ocp_fault && en_a && en_b && !por) |=> (rdy_pull_low && shutdown_req));

  assert_por_clears_ovp_R10: assert property (@(posedge clk) disable iff (rst)
    por |=> !ovp_fault);

  assert_ovp_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (ovp_fault && !por && $stable(en_a) && $stable(en_b) && $stable(por))
      |=> ovp_fault);

  assert_ovp_blocks_ready_R9: assert property (@(posedge clk) disable iff (rst)
    (ovp_fault && $stable(en_a) && $stable(en_b) && $stable(por)) |=> rdy_pull_low);
endmodule

bind pg_ovp_sup pg_ovp_sup_chk u_chk (
  .clk(clk), .rst(rst), .en_a(en_a), .en_b(en_b), .por(por),
  .ss_done(ss_done), .ocp_fault(ocp_fault), .rdy_pull_low(rdy_pull_low),
  .ovp_fault(ovp_fault), .shutdown_req(shutdown_req)
);

// File: tb/tb_pg_ovp_sup.sv
module tb_pg_ovp_sup;
  logic       clk = 1'b0;
  logic       rst, en_a, en_b, por, ss_done, ocp_fault;
  logic [9:0] dac_code, vout_code;
  logic [7:0] vid_code, cfg_reg;
  logic       rdy_pull_low, ovp_fault, shutdown_req;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pg_ovp_sup dut (
    .clk(clk), .rst(rst), .en_a(en_a), .en_b(en_b), .por(por),
    .ss_done(ss_done), .ocp_fault(ocp_fault), .dac_code(dac_code),
    .vout_code(vout_code), .vid_code(vid_code), .cfg_reg(cfg_reg),
    .rdy_pull_low(rdy_pull_low), .ovp_fault(ovp_fault),
    .shutdown_req(shutdown_req)
  );

  task automatic chk(input bit act, input bit exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; en_a = 0; en_b = 0; por = 0; ss_done = 0; ocp_fault = 0;
    dac_code = 10'd240; vout_code = 10'd0; vid_code = 8'h40; cfg_reg = 8'h00;
    cyc(3);
    rst = 0;
  endtask

  task automatic bring_up();
    en_a = 1; en_b = 1; por = 0; ss_done = 1;
    cyc(3);
  endtask

  task automatic t_reset_R1();
    do_reset();
    chk(rdy_pull_low, 1, "R1 ready line low during reset");
    chk(ovp_fault, 0, "R1 ovp clear during reset");
    chk(shutdown_req, 0, "R1 no shutdown during reset");
    cyc(1);
    chk(rdy_pull_low, 1, "R1 ready line low after reset");
  endtask

  task automatic t_softstart_R2();
    do_reset();
    en_a = 1; en_b = 1;
    cyc(5);
    chk(rdy_pull_low, 1, "R2 no ready before soft-start done");
    ss_done = 1;
    cyc(1);
    chk(rdy_pull_low, 0, "R2 ready one edge after ss_done");
  endtask

  task automatic t_disable_R3();
    do_reset(); bring_up();
    en_a = 0; cyc(1);
    chk(rdy_pull_low, 1, "R3 first enable low drops ready");
    en_a = 1; cyc(3);
    chk(rdy_pull_low, 0, "R3 ready back after re-enable");
    en_b = 0; cyc(1);
    chk(rdy_pull_low, 1, "R3 second enable low drops ready");
    en_b = 1; cyc(3);
    por = 1; cyc(1);
    chk(rdy_pull_low, 1, "R3 por drops ready");
    por = 0;
  endtask

  task automatic t_ocp_R4();
    do_reset(); bring_up();
    ocp_fault = 1; cyc(1); ocp_fault = 0;
    chk(rdy_pull_low, 1, "R4 ocp drops ready");
    chk(shutdown_req, 1, "R4 ocp requests shutdown");
    cyc(5);
    chk(rdy_pull_low, 1, "R4 ready stays low after ocp clears");
    chk(shutdown_req, 1, "R4 shutdown held after ocp clears");
    en_a = 0; cyc(2); en_a = 1; cyc(3);
    chk(rdy_pull_low, 0, "R4 ready back after enable cycle");
    chk(shutdown_req, 0, "R4 shutdown released after enable cycle");
  endtask

  task automatic t_vidoff_R5();
    do_reset(); cfg_reg = 8'h00; bring_up();
    vid_code = 8'h00; cyc(1);
    chk(rdy_pull_low, 1, "R5 off-code drops ready");
    chk(shutdown_req, 0, "R5 off-code is no shutdown");
    vid_code = 8'h50; cyc(2);
    chk(rdy_pull_low, 0, "R5 ready back on new code");
  endtask

  task automatic t_keep_R6();
    do_reset(); cfg_reg = 8'h01; bring_up();
    vid_code = 8'h00; cyc(5);
    chk(rdy_pull_low, 0, "R6 config 01h keeps ready on off-code");
    vid_code = 8'h40;
  endtask

  task automatic t_fixed_R7();
    do_reset();
    dac_code = 10'd20; vout_code = 10'd460; cyc(4);
    chk(ovp_fault, 0, "R7 disabled, vout at 460 no trip");
    vout_code = 10'd461; cyc(1);
    chk(ovp_fault, 1, "R7 disabled, vout 461 trips");
    vout_code = 10'd0; por = 1; cyc(1); por = 0; cyc(1);
    chk(ovp_fault, 0, "R9 por clears ovp");
    en_a = 1; en_b = 1; vout_code = 10'd300; cyc(4);
    chk(ovp_fault, 0, "R7 ramping uses fixed limit, not dac");
  endtask

  task automatic t_track_R8();
    do_reset();
    dac_code = 10'd300; en_a = 1; en_b = 1; vout_code = 10'd400; cyc(4);
    chk(ovp_fault, 0, "R7 ramp, vout 400 under fixed limit");
    vout_code = 10'd300; ss_done = 1; cyc(2);
    chk(rdy_pull_low, 0, "R8 ready reached");
    vout_code = 10'd336; cyc(3);
    chk(ovp_fault, 0, "R8 vout at dac+36 no trip");
    vout_code = 10'd337; cyc(1);
    chk(ovp_fault, 1, "R8 vout dac+37 trips below 460");
    cyc(1);
    chk(rdy_pull_low, 1, "R9 ovp forces ready low");
    chk(shutdown_req, 1, "R9 ovp raises shutdown");
    vout_code = 10'd0; cyc(4);
    chk(ovp_fault, 1, "R9 ovp sticky after voltage falls");
    chk(rdy_pull_low, 1, "R9 ready stays low while ovp latched");
    en_b = 0; cyc(2);
    chk(ovp_fault, 1, "R9 ovp held while disabled");
    en_b = 1; cyc(1);
    chk(ovp_fault, 0, "R9 enable rise clears ovp");
    cyc(2);
    chk(rdy_pull_low, 0, "R9 ready back after enable cycle");
  endtask

  task automatic t_por_R10();
    do_reset();
    por = 1; vout_code = 10'd1000; cyc(4);
    chk(ovp_fault, 0, "R10 no ovp during por");
    por = 0; cyc(1);
    chk(ovp_fault, 1, "R10 ovp active after por");
  endtask

  initial begin
    t_reset_R1();
    t_softstart_R2();
    t_disable_R3();
    t_ocp_R4();
    t_vidoff_R5();
    t_keep_R6();
    t_fixed_R7();
    t_track_R8();
    t_por_R10();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule